// File: doc/BRIEF.md
# Dual-Issue Instruction Word Dispatcher

This block sits between instruction fetch and an execution stage. It takes one 32-bit fetched word and splits it into one or two issue slots, depending on a two-bit format field in the top of the word. A word is either a single long operation with a 30-bit payload, or a pair of 15-bit short operations. A pair issues in one of two fixed orders, or as a parallel pair. In a parallel pair, a short operation marked as a condition test can decide whether its partner runs.

The execution stage returns three feedback signals in the same cycle as the first slot: branch taken, exception and condition result. The dispatcher uses them to decide whether the second slot is issued. The fetch side presents a word with a valid/ready handshake. Along with the word it presents two predecode flags that say whether the left or the right short operation is a condition test. Each issued slot carries a type tag for downstream performance counting. Two single-cycle pulses report a second slot that was dropped: one for a false condition, one for a taken branch.

Top module: `dual_slot_dispatch`

## Requirements
- R1: During and after synchronous active-low reset, `slot_valid`, `skip_cond_false` and `skip_branch` are 0 and `word_ready` is 1.
- R2: `word_ready` is 1 only while no slot is being issued. A word is taken on a clock edge where `word_valid` and `word_ready` are both 1. Its first slot is presented in the following cycle with `slot_valid` = 1. While the dispatcher is busy, a word offered on the input is not taken.
- R3: A format field (bits 31:30) of 2'b11 gives one slot with type 0 (long) and payload bits 29:0, after which the dispatcher is idle again.
- R4: Format 2'b01 issues the left field (bits 29:15) as type 1 (left) and then, in the next cycle, the right field (bits 14:0) as type 2 (right). Short payloads are zero-extended to 30 bits.
- R5: Format 2'b10 issues the right field as type 2 first, then the left field as type 1.
- R6: In formats 2'b01 and 2'b10, `fb_branch` or `fb_except` high during the first slot suppresses the second slot. `skip_branch` pulses in that cycle when `fb_branch` is high and `fb_except` is low. `skip_cond_false` and `skip_branch` are never high together.
- R7: Format 2'b00 with neither test flag issues the left field as type 3 (left-parallel), then the right field as type 4 (right-parallel). Only `fb_except` during the first slot suppresses the second; `fb_branch` does not.
- R8: Format 2'b00 with `left_is_test` set issues the left field as type 5 (cond-test). The right field follows as type 6 (cond-exec) only if `fb_cond` is 1 during the test. Otherwise `skip_cond_false` pulses during the test slot and no second slot follows.
- R9: Format 2'b00 with only `right_is_test` set is the mirror of R8: the right field is the type-5 test and the left field is the gated type-6 slot.
- R10: Format 2'b00 with both test flags set behaves as R8: the left field is the test.
- R11: Feedback inputs have no effect during a long slot, during a second slot or while idle. No skip pulse appears there, and the next state is unchanged.
- R12: The test flags are ignored for formats 2'b01, 2'b10 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Fetched word is offered |
| word_data | input | 32 | Fetched instruction word |
| left_is_test | input | 1 | Predecode: left short operation is a condition test |
| right_is_test | input | 1 | Predecode: right short operation is a condition test |
| word_ready | output | 1 | Dispatcher can take a word this cycle |
| slot_valid | output | 1 | An issue slot is presented |
| slot_payload | output | 30 | Operation bits of the slot, short ones zero-extended |
| slot_type | output | 3 | Slot type tag (0 long .. 6 cond-exec) |
| fb_branch | input | 1 | First slot changed the program counter |
| fb_except | input | 1 | First slot raised an exception |
| fb_cond | input | 1 | Condition-test result of the first slot |
| skip_cond_false | output | 1 | Second slot dropped on a false condition |
| skip_branch | output | 1 | Second slot dropped on a taken branch |

## Verification
The hardest situation to reach from the ports is a pair whose second slot depends on feedback given in exactly the one cycle of the first slot. The same feedback must then be proven ignored in every other cycle. The stimulus drives the chosen branch, exception and condition values only in the first-slot cycle and forces all feedback high in every second-slot cycle. It also offers a different word on the input throughout the busy cycles, so that any leak of feedback or premature acceptance shows up. A directed list covers each format against each feedback combination and flag setting, followed by a long random sweep with idle gaps.

// File: rtl/dsd_pkg.sv
// Shared types of the dual-slot dispatcher.
// Assumes: format codes sit in the top two bits of the fetched word.
package dsd_pkg;

    typedef enum logic [1:0] {
        FMT_PAR  = 2'b00,
        FMT_LR   = 2'b01,
        FMT_RL   = 2'b10,
        FMT_LONG = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        ST_LONG  = 3'd0,
        ST_LEFT  = 3'd1,
        ST_RIGHT = 3'd2,
        ST_LPAR  = 3'd3,
        ST_RPAR  = 3'd4,
        ST_CTEST = 3'd5,
        ST_CEXEC = 3'd6
    } slot_type_e;

    typedef enum logic [1:0] {
        KIND_LONG,
        KIND_SEQ,
        KIND_PAR_TEST,
        KIND_PAR_PLAIN
    } pair_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND
    } phase_e;

endpackage

// File: rtl/dsd_word_split.sv
// Combinational split of a held word into first and second slot contents.
// Assumes: WORD_W - 2 == 2 * SHORT_W, left field above right field.
module dsd_word_split
    import dsd_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int SHORT_W = 15
) (
    input  logic [WORD_W-1:0]   word,
    input  logic                left_test,
    input  logic                right_test,
    output pair_kind_e          kind,
    output logic [WORD_W-3:0]   first_pay,
    output slot_type_e          first_type,
    output logic [WORD_W-3:0]   second_pay,
    output slot_type_e          second_type
);
    localparam int PAY_W = WORD_W - 2;
    localparam int PAD_W = PAY_W - SHORT_W;

    fmt_e              fmt;
    logic [PAY_W-1:0]  left_ext;
    logic [PAY_W-1:0]  right_ext;

    assign fmt       = fmt_e'(word[WORD_W-1:WORD_W-2]);
    assign left_ext  = {{PAD_W{1'b0}}, word[2*SHORT_W-1:SHORT_W]};
    assign right_ext = {{PAD_W{1'b0}}, word[SHORT_W-1:0]};

    // Select slot order, payloads and type tags from the format and flags.
    always_comb begin
        kind        = KIND_LONG;
        first_pay   = word[PAY_W-1:0];
        first_type  = ST_LONG;
        second_pay  = right_ext;
        second_type = ST_RIGHT;
        case (fmt)
            FMT_LONG: begin
                kind       = KIND_LONG;
                first_pay  = word[PAY_W-1:0];
                first_type = ST_LONG;
            end
            FMT_LR: begin
                kind        = KIND_SEQ;
                first_pay   = left_ext;
                first_type  = ST_LEFT;
                second_pay  = right_ext;
                second_type = ST_RIGHT;
            end
            FMT_RL: begin
                kind        = KIND_SEQ;
                first_pay   = right_ext;
                first_type  = ST_RIGHT;
                second_pay  = left_ext;
                second_type = ST_LEFT;
            end
            default: begin
                if (left_test) begin
                    kind        = KIND_PAR_TEST;
                    first_pay   = left_ext;
                    first_type  = ST_CTEST;
                    second_pay  = right_ext;
                    second_type = ST_CEXEC;
                end else if (right_test) begin
                    kind        = KIND_PAR_TEST;
                    first_pay   = right_ext;
                    first_type  = ST_CTEST;
                    second_pay  = left_ext;
                    second_type = ST_CEXEC;
                end else begin
                    kind        = KIND_PAR_PLAIN;
                    first_pay   = left_ext;
                    first_type  = ST_LPAR;
                    second_pay  = right_ext;
                    second_type = ST_RPAR;
                end
            end
        endcase
    end

endmodule

// File: rtl/dsd_issue_gate.sv
// Decides from same-cycle feedback whether the second slot issues,
// and raises the skip pulses. Assumes feedback is valid in the first-slot cycle.
module dsd_issue_gate
    import dsd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        first_active,
    input  pair_kind_e  kind,
    input  logic        fb_branch,
    input  logic        fb_except,
    input  logic        fb_cond,
    output logic        issue_second,
    output logic        skip_cond_false,
    output logic        skip_branch
);
    // Apply the per-kind suppression rule, qualified by the first slot.
    always_comb begin
        issue_second    = 1'b0;
        skip_cond_false = 1'b0;
        skip_branch     = 1'b0;
        if (first_active) begin
            case (kind)
                KIND_SEQ: begin
                    issue_second = !(fb_branch || fb_except);
                    skip_branch  = fb_branch && !fb_except;
                end
                KIND_PAR_TEST: begin
                    issue_second    = fb_cond;
                    skip_cond_false = !fb_cond;
                end
                KIND_PAR_PLAIN: begin
                    issue_second = !fb_except;
                end
                default: issue_second = 1'b0;
            endcase
        end
    end

    AST_SKIP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip_cond_false && skip_branch)); // R6
    AST_PULSE_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_cond_false || skip_branch) |-> first_active && !issue_second); // R11

endmodule

// File: rtl/dsd_issue_fsm.sv
// Three-phase issue sequencer holding the accepted word and its flags.
// Assumes: a word is accepted only in the idle phase.
module dsd_issue_fsm
    import dsd_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              left_is_test,
    input  logic              right_is_test,
    input  logic              issue_second,
    output logic              word_ready,
    output phase_e            phase,
    output logic [WORD_W-1:0] word_q,
    output logic              left_test_q,
    output logic              right_test_q
);
    logic accept;

    assign word_ready = (phase == PH_IDLE);
    assign accept     = word_valid && word_ready;

    // Advance the issue phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:   phase <= accept ? PH_FIRST : PH_IDLE;
                PH_FIRST:  phase <= issue_second ? PH_SECOND : PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // Capture the word and its predecode flags on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q       <= '0;
            left_test_q  <= 1'b0;
            right_test_q <= 1'b0;
        end else if (accept) begin
            word_q       <= word_data;
            left_test_q  <= left_is_test;
            right_test_q <= right_is_test;
        end
    end

    AST_ACCEPT_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> phase == PH_FIRST); // R2
    AST_SECOND_FOLLOWS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SECOND |-> $past(phase == PH_FIRST && issue_second)); // R2

endmodule

// File: rtl/dual_slot_dispatch.sv
// Top of the dual-slot dispatcher: takes a fetched word and issues one long
// slot or two short slots, gating the second slot on execution feedback.
// Assumes: feedback is returned in the same cycle as the first slot.
module dual_slot_dispatch
    import dsd_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int SHORT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              left_is_test,
    input  logic              right_is_test,
    output logic              word_ready,
    output logic              slot_valid,
    output logic [WORD_W-3:0] slot_payload,
    output logic [2:0]        slot_type,
    input  logic              fb_branch,
    input  logic              fb_except,
    input  logic              fb_cond,
    output logic              skip_cond_false,
    output logic              skip_branch
);
    localparam int PAY_W = WORD_W - 2;

    phase_e            phase;
    logic [WORD_W-1:0] word_q;
    logic              left_test_q;
    logic              right_test_q;
    logic              issue_second;
    pair_kind_e        kind;
    logic [PAY_W-1:0]  first_pay;
    logic [PAY_W-1:0]  second_pay;
    slot_type_e        first_type;
    slot_type_e        second_type;

    dsd_issue_fsm #(.WORD_W(WORD_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid   (word_valid),
        .word_data    (word_data),
        .left_is_test (left_is_test),
        .right_is_test(right_is_test),
        .issue_second (issue_second),
        .word_ready   (word_ready),
        .phase        (phase),
        .word_q       (word_q),
        .left_test_q  (left_test_q),
        .right_test_q (right_test_q)
    );

    dsd_word_split #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) split_i (
        .word       (word_q),
        .left_test  (left_test_q),
        .right_test (right_test_q),
        .kind       (kind),
        .first_pay  (first_pay),
        .first_type (first_type),
        .second_pay (second_pay),
        .second_type(second_type)
    );

    dsd_issue_gate gate_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .first_active   (phase == PH_FIRST),
        .kind           (kind),
        .fb_branch      (fb_branch),
        .fb_except      (fb_except),
        .fb_cond        (fb_cond),
        .issue_second   (issue_second),
        .skip_cond_false(skip_cond_false),
        .skip_branch    (skip_branch)
    );

    // Present the slot of the current phase.
    always_comb begin
        slot_valid   = (phase != PH_IDLE);
        slot_payload = (phase == PH_SECOND) ? second_pay : first_pay;
        slot_type    = (phase == PH_SECOND) ? second_type : first_type;
    end

    AST_LONG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid && slot_type == ST_LONG |=> !slot_valid); // R3
    AST_SEQ_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FIRST && kind == KIND_SEQ && (fb_branch || fb_except) |=> !slot_valid); // R6
    AST_PAR_EXC_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FIRST && kind == KIND_PAR_PLAIN && fb_except |=> !slot_valid); // R7
    AST_CEXEC_NEEDS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid && slot_type == ST_CEXEC |-> $past(slot_valid && slot_type == ST_CTEST && fb_cond)); // R8
    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |-> !skip_cond_false && !skip_branch); // R11

endmodule

// File: tb/dual_slot_dispatch_tb_top.sv
module dual_slot_dispatch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        left_is_test = 1'b0;
    logic        right_is_test = 1'b0;
    logic        word_ready;
    logic        slot_valid;
    logic [29:0] slot_payload;
    logic [2:0]  slot_type;
    logic        fb_branch = 1'b0;
    logic        fb_except = 1'b0;
    logic        fb_cond = 1'b0;
    logic        skip_cond_false;
    logic        skip_branch;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int          mstate = 0;
    logic [31:0] mw = '0;
    bit          ml = 0;
    bit          mr = 0;

    always #10 clk = ~clk;

    dual_slot_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .left_is_test(left_is_test), .right_is_test(right_is_test),
        .word_ready(word_ready), .slot_valid(slot_valid), .slot_payload(slot_payload),
        .slot_type(slot_type), .fb_branch(fb_branch), .fb_except(fb_except),
        .fb_cond(fb_cond), .skip_cond_false(skip_cond_false), .skip_branch(skip_branch)
    );

    function automatic logic [29:0] lf(logic [31:0] w);
        return {15'b0, w[29:15]};
    endfunction

    function automatic logic [29:0] rf(logic [31:0] w);
        return {15'b0, w[14:0]};
    endfunction

    task automatic compare(string tag, bit ev, bit er, bit ec, bit eb, int et, logic [29:0] ep);
        bit bad;
        checks++;
        bad = (slot_valid !== ev) || (word_ready !== er) ||
              (skip_cond_false !== ec) || (skip_branch !== eb);
        if (ev && ((slot_type !== et[2:0]) || (slot_payload !== ep))) bad = 1;
        if (bad) begin
            errors++;
            $display("FAIL %s: act v=%0b rdy=%0b skc=%0b skb=%0b type=%0d pay=%h exp v=%0b rdy=%0b skc=%0b skb=%0b type=%0d pay=%h",
                     tag, slot_valid, word_ready, skip_cond_false, skip_branch, slot_type, slot_payload,
                     ev, er, ec, eb, et, ep);
        end
    endtask

    // One cycle: evaluate model against outputs, then advance at the edge.
    task automatic step();
        bit ev, er, ec, eb; int et; logic [29:0] ep; int nxt; string tag;
        logic [1:0] f;
        #2;
        ev = 0; er = 0; ec = 0; eb = 0; et = 0; ep = '0; nxt = 0; tag = "R2";
        f = mw[31:30];
        if (mstate == 0) begin
            er = 1;
            nxt = word_valid ? 1 : 0;
            tag = "R2";
        end else if (mstate == 1) begin
            ev = 1;
            if (f == 2'b11) begin
                et = 0; ep = mw[29:0]; nxt = 0; tag = "R3";
                if (fb_branch || fb_except || fb_cond) tag = "R11";
            end else if (f == 2'b01 || f == 2'b10) begin
                if (f == 2'b01) begin et = 1; ep = lf(mw); tag = "R4"; end
                else begin et = 2; ep = rf(mw); tag = "R5"; end
                eb = fb_branch && !fb_except;
                nxt = (fb_branch || fb_except) ? 0 : 2;
                if (fb_branch || fb_except) tag = "R6";
                if (ml || mr) tag = "R12";
            end else if (ml) begin
                et = 5; ep = lf(mw); ec = !fb_cond; nxt = fb_cond ? 2 : 0;
                tag = mr ? "R10" : "R8";
            end else if (mr) begin
                et = 5; ep = rf(mw); ec = !fb_cond; nxt = fb_cond ? 2 : 0; tag = "R9";
            end else begin
                et = 3; ep = lf(mw); nxt = fb_except ? 0 : 2; tag = "R7";
            end
        end else begin
            ev = 1; nxt = 0; tag = "R11";
            if (f == 2'b01) begin et = 2; ep = rf(mw); end
            else if (f == 2'b10) begin et = 1; ep = lf(mw); end
            else if (ml) begin et = 6; ep = rf(mw); end
            else if (mr) begin et = 6; ep = lf(mw); end
            else begin et = 4; ep = rf(mw); end
        end
        compare(tag, ev, er, ec, eb, et, ep);
        if (mstate == 0 && word_valid) begin
            mw = word_data; ml = left_is_test; mr = right_is_test;
        end
        @(posedge clk);
        mstate = nxt;
        @(negedge clk);
    endtask

    // Offer one word, apply feedback to its first slot, all-ones afterwards,
    // and keep a decoy word on the input while busy.
    task automatic run_word(logic [31:0] w, bit lt, bit rt, bit br, bit ex, bit cd);
        word_valid = 1; word_data = w; left_is_test = lt; right_is_test = rt;
        fb_branch = 1; fb_except = 1; fb_cond = 1;
        step();
        word_data = ~w; left_is_test = !lt; right_is_test = !rt;
        fb_branch = br; fb_except = ex; fb_cond = cd;
        step();
        while (mstate != 0) begin
            fb_branch = 1; fb_except = 1; fb_cond = 1;
            step();
        end
        word_valid = 0;
        fb_branch = 0; fb_except = 0; fb_cond = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        #2;
        // R1: reset state
        checks++;
        if (slot_valid !== 0 || word_ready !== 1 || skip_cond_false !== 0 || skip_branch !== 0) begin
            errors++;
            $display("FAIL R1: act v=%0b rdy=%0b skc=%0b skb=%0b exp v=0 rdy=1 skc=0 skb=0",
                     slot_valid, word_ready, skip_cond_false, skip_branch);
        end
        @(negedge clk);
        rst_n = 1;
        step();
        // R3 / R11: long word, feedback ignored
        run_word({2'b11, 30'h2ABC_1234}, 0, 0, 1, 1, 0);
        run_word({2'b11, 30'h3FFF_FFFF}, 1, 1, 0, 0, 0);
        // R4, R5: ordered pairs
        run_word({2'b01, 15'h1234, 15'h4321}, 0, 0, 0, 0, 0);
        run_word({2'b10, 15'h7FFF, 15'h0001}, 0, 0, 0, 0, 1);
        // R6: suppression in ordered pairs
        run_word({2'b01, 15'h0AAA, 15'h5555}, 0, 0, 1, 0, 1);
        run_word({2'b10, 15'h0F0F, 15'h70F0}, 0, 0, 0, 1, 0);
        run_word({2'b01, 15'h1111, 15'h2222}, 0, 0, 1, 1, 0);
        // R12: flags ignored outside parallel format
        run_word({2'b01, 15'h3333, 15'h4444}, 1, 0, 0, 0, 0);
        run_word({2'b10, 15'h5555, 15'h6666}, 0, 1, 0, 0, 0);
        run_word({2'b11, 30'h0000_0001}, 1, 0, 0, 0, 0);
        // R7: plain parallel pairs
        run_word({2'b00, 15'h1357, 15'h2468}, 0, 0, 0, 0, 0);
        run_word({2'b00, 15'h1357, 15'h2468}, 0, 0, 1, 0, 0);
        run_word({2'b00, 15'h7531, 15'h0246}, 0, 0, 0, 1, 1);
        // R8, R9, R10: condition-gated pairs
        run_word({2'b00, 15'h0101, 15'h0202}, 1, 0, 0, 0, 1);
        run_word({2'b00, 15'h0101, 15'h0202}, 1, 0, 1, 1, 0);
        run_word({2'b00, 15'h0303, 15'h0404}, 0, 1, 0, 0, 1);
        run_word({2'b00, 15'h0303, 15'h0404}, 0, 1, 0, 1, 0);
        run_word({2'b00, 15'h0505, 15'h0606}, 1, 1, 0, 0, 1);
        run_word({2'b00, 15'h0505, 15'h0606}, 1, 1, 0, 0, 0);
        // Random sweep with idle gaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            run_word(r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 4) == 0) begin
                fb_branch = 1'($urandom); fb_except = 1'($urandom); fb_cond = 1'($urandom);
                step();
                fb_branch = 0; fb_except = 0; fb_cond = 0;
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule